// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block turns a decoded instruction's mode code, address field and register select into the operand for an accumulator load. When a request is accepted, it captures the instruction fields and the current program counter and index register. It then forms the effective address for the chosen mode and issues zero, one or two memory reads. It returns the operand together with a one-cycle done pulse.

Two modes change the register they use as a pointer. The post-step mode reads through the register and then writes back the register plus one. The pre-step mode writes back the register minus one and reads at that lowered address. The register file and the memory are outside the block. The register read is combinational on the select the block drives. Memory data returns on the cycle after a read is issued. All address arithmetic is 16 bits wide and wraps.

Top module: `opfetch_unit`

## Requirements
- R1: While reset is held low and on the first cycle after it, done, err, mem_rd_en and rf_we are all 0 and operand is 0.
- R2: Mode code 0 returns the memory word at the address field, using one read.
- R3: Mode code 1 reads the memory word at the address field and uses it as a pointer. It then returns the word at that pointer, for exactly two reads.
- R4: Mode code 2 returns the memory word at program counter plus address field, modulo 2^16, using one read.
- R5: Mode code 3 returns the address field itself and makes no memory read.
- R6: Mode code 4 returns the memory word at address field plus index register, modulo 2^16, using one read.
- R7: Mode code 5 returns the selected register's value, makes no memory read and leaves the register unchanged.
- R8: Mode code 6 returns the memory word at the address held in the selected register, using one read, and leaves the register unchanged.
- R9: Mode code 7 returns the memory word at the selected register's old value, using one read. The register then holds the old value plus 1, modulo 2^16.
- R10: Mode code 8 decrements the selected register by 1, modulo 2^16. It returns the memory word at the decremented value, using one read.
- R11: Mode codes 9 to 15 answer with done and err both 1 and operand 0. They make no memory read and no register write.
- R12: Each accepted request yields exactly one done pulse, one cycle wide. A request raised while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a fetch; sampled only when idle |
| mode | input | 4 | Addressing-mode code |
| addr_fld | input | 16 | Address field of the instruction |
| reg_sel | input | 3 | Register select for register-based modes |
| pc | input | 16 | Program counter value |
| idx | input | 16 | Index register value |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory data, valid the cycle after the strobe |
| rf_sel | output | 3 | Register-file read/write select |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 16 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal mode, valid with done |
| operand | output | 16 | Fetched operand, valid with done |

## Verification
A corrupted captured field or a wrong mode decode shows up on the mem_addr value of the first read, one cycle after the request. It also shows up in the operand two to four cycles after the request. A sequencer stuck in the wrong state gives a wrong read count, which is visible before done. It can also give a missing or doubled done pulse. A wrong pointer step is not visible in that fetch's operand for the post-step mode. It shows up in the register-file content read back right after done, and in the address of the next fetch that uses that register.

// File: rtl/opf_pkg.sv
// Package: shared mode codes and sequencer states for the operand fetch unit.
// Assumes a 4-bit mode code; codes above MD_PREDEC are illegal.
package opf_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_DIRECT  = 4'd0,
        MD_INDIR   = 4'd1,
        MD_PCREL   = 4'd2,
        MD_IMMED   = 4'd3,
        MD_INDEXED = 4'd4,
        MD_REG     = 4'd5,
        MD_REGIND  = 4'd6,
        MD_POSTINC = 4'd7,
        MD_PREDEC  = 4'd8
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_PTR  = 2'd2,
        ST_DATA = 2'd3
    } state_e;
endpackage

// File: rtl/opf_ea_gen.sv
// Effective-address generator: purely combinational decode of the captured
// mode into an address, a read/indirect need, and a pointer-step value.
// Assumes the caller holds all inputs stable for the cycle they are used.
module opf_ea_gen
    import opf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [AW-1:0]     fld_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [AW-1:0]     idx_i,
    input  logic [AW-1:0]     reg_i,
    output logic [AW-1:0]     ea_o,
    output logic [AW-1:0]     step_o,
    output logic              need_rd_o,
    output logic              indir_o,
    output logic              step_we_o,
    output logic              legal_o
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // Decode mode into address and side-effect controls.
    always_comb begin
        ea_o      = fld_i;
        step_o    = reg_i;
        need_rd_o = 1'b0;
        indir_o   = 1'b0;
        step_we_o = 1'b0;
        legal_o   = 1'b1;
        case (mode_i)
            MD_DIRECT:  need_rd_o = 1'b1;
            MD_INDIR: begin
                need_rd_o = 1'b1;
                indir_o   = 1'b1;
            end
            MD_PCREL: begin
                ea_o      = fld_i + pc_i;
                need_rd_o = 1'b1;
            end
            MD_IMMED:   ;
            MD_INDEXED: begin
                ea_o      = fld_i + idx_i;
                need_rd_o = 1'b1;
            end
            MD_REG:     ;
            MD_REGIND: begin
                ea_o      = reg_i;
                need_rd_o = 1'b1;
            end
            MD_POSTINC: begin
                ea_o      = reg_i;
                step_o    = reg_i + ONE;
                step_we_o = 1'b1;
                need_rd_o = 1'b1;
            end
            MD_PREDEC: begin
                ea_o      = reg_i - ONE;
                step_o    = reg_i - ONE;
                step_we_o = 1'b1;
                need_rd_o = 1'b1;
            end
            default:    legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/opf_seq.sv
// Fetch sequencer: captures a request when idle, walks through address,
// pointer and data cycles, and returns a registered operand with a one-cycle
// done pulse. Assumes memory data is valid one cycle after a read strobe.
module opf_seq
    import opf_pkg::*;
#(
    parameter int AW  = 16,
    parameter int RSW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [AW-1:0]     fld_i,
    input  logic [RSW-1:0]    sel_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [AW-1:0]     idx_i,
    output logic [MODE_W-1:0] mode_q,
    output logic [AW-1:0]     fld_q,
    output logic [RSW-1:0]    sel_q,
    output logic [AW-1:0]     pc_q,
    output logic [AW-1:0]     idx_q,
    input  logic [AW-1:0]     ea_i,
    input  logic              need_rd_i,
    input  logic              indir_i,
    input  logic              step_we_i,
    input  logic              legal_i,
    input  logic [AW-1:0]     reg_i,
    input  logic [AW-1:0]     mem_rdata_i,
    output logic              mem_rd_en_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic              rf_we_o,
    output logic              done_o,
    output logic              err_o,
    output logic [AW-1:0]     operand_o
);
    state_e st;

    // State, captured fields and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            mode_q    <= '0;
            fld_q     <= '0;
            sel_q     <= '0;
            pc_q      <= '0;
            idx_q     <= '0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            operand_o <= '0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (st)
                ST_IDLE: if (req_i) begin
                    mode_q <= mode_i;
                    fld_q  <= fld_i;
                    sel_q  <= sel_i;
                    pc_q   <= pc_i;
                    idx_q  <= idx_i;
                    st     <= ST_CALC;
                end
                ST_CALC: begin
                    if (!legal_i) begin
                        done_o    <= 1'b1;
                        err_o     <= 1'b1;
                        operand_o <= '0;
                        st        <= ST_IDLE;
                    end else if (need_rd_i) begin
                        st <= indir_i ? ST_PTR : ST_DATA;
                    end else begin
                        done_o    <= 1'b1;
                        operand_o <= (mode_q == MD_IMMED) ? fld_q : reg_i;
                        st        <= ST_IDLE;
                    end
                end
                ST_PTR:  st <= ST_DATA;
                ST_DATA: begin
                    done_o    <= 1'b1;
                    operand_o <= mem_rdata_i;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory and register-file strobes for the current state.
    always_comb begin
        mem_rd_en_o = ((st == ST_CALC) && legal_i && need_rd_i) || (st == ST_PTR);
        mem_addr_o  = (st == ST_PTR) ? mem_rdata_i : ea_i;
        rf_we_o     = (st == ST_CALC) && step_we_i;
    end

    // R12: done lasts a single cycle.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: err is only ever reported with done.
    p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
    // R11: an illegal code is answered on the next cycle.
    p_illegal_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CALC && !legal_i) |=> (done_o && err_o));
    // R3: the pointer read is followed at once by a second read.
    p_second_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en_o && st == ST_CALC && indir_i) |=> mem_rd_en_o);
    // R5: no read is issued while a result is being reported.
    p_no_read_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_rd_en_o);
endmodule

// File: rtl/opfetch_unit.sv
// Operand fetch unit top: joins the sequencer and the address generator,
// drives the memory read port and the register-file port. Assumes an
// external register file with combinational read and clocked write.
module opfetch_unit
    import opf_pkg::*;
#(
    parameter int AW  = 16,
    parameter int RSW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     addr_fld,
    input  logic [RSW-1:0]    reg_sel,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     idx,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [AW-1:0]     mem_rdata,
    output logic [RSW-1:0]    rf_sel,
    input  logic [AW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [AW-1:0]     rf_wdata,
    output logic              done,
    output logic              err,
    output logic [AW-1:0]     operand
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [MODE_W-1:0] mode_q;
    logic [AW-1:0]     fld_q, pc_q, idx_q, ea, step;
    logic              need_rd, indir, step_we, legal;

    opf_seq #(.AW(AW), .RSW(RSW)) seq_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
        .fld_i(addr_fld), .sel_i(reg_sel), .pc_i(pc), .idx_i(idx),
        .mode_q(mode_q), .fld_q(fld_q), .sel_q(rf_sel), .pc_q(pc_q),
        .idx_q(idx_q), .ea_i(ea), .need_rd_i(need_rd), .indir_i(indir),
        .step_we_i(step_we), .legal_i(legal), .reg_i(rf_rdata),
        .mem_rdata_i(mem_rdata), .mem_rd_en_o(mem_rd_en),
        .mem_addr_o(mem_addr), .rf_we_o(rf_we), .done_o(done),
        .err_o(err), .operand_o(operand)
    );

    opf_ea_gen #(.AW(AW)) ea_i (
        .mode_i(mode_q), .fld_i(fld_q), .pc_i(pc_q), .idx_i(idx_q),
        .reg_i(rf_rdata), .ea_o(ea), .step_o(step), .need_rd_o(need_rd),
        .indir_o(indir), .step_we_o(step_we), .legal_o(legal)
    );

    assign rf_wdata = step;

    // R9 / R10: a register write is always a one-step move of the pointer.
    p_step_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_wdata == rf_rdata + ONE || rf_wdata == rf_rdata - ONE));
    // R10: a pointer write is paired with a read at the old or new pointer.
    p_step_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_rd_en && (mem_addr == rf_rdata || mem_addr == rf_wdata)));
endmodule

// File: tb/opfetch_unit_tb_top.sv
// Scoreboard bench: the driver task pushes expected results, the monitor
// pops and compares them on each done pulse.
module opfetch_unit_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 16, RSW = 3, NREG = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic [3:0]      mode = '0;
    logic [AW-1:0]   addr_fld = '0, pc = '0, idx = '0;
    logic [RSW-1:0]  reg_sel = '0;
    logic            mem_rd_en, rf_we, done, err;
    logic [AW-1:0]   mem_addr, rf_wdata, operand, rf_rdata;
    logic [AW-1:0]   mem_rdata = '0;
    logic [RSW-1:0]  rf_sel;

    opfetch_unit #(.AW(AW), .RSW(RSW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .addr_fld(addr_fld),
        .reg_sel(reg_sel), .pc(pc), .idx(idx), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rf_sel(rf_sel),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .done(done), .err(err), .operand(operand)
    );

    function automatic logic [AW-1:0] mem_f(input logic [AW-1:0] a);
        return {a[6:0], a[15:7]} ^ 16'h3c96;
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_f(mem_addr);

    // Register file model, with a preload port for the bench.
    logic [AW-1:0]  rf [NREG];
    logic           tb_we = 1'b0;
    logic [RSW-1:0] tb_sel = '0;
    logic [AW-1:0]  tb_val = '0;
    assign rf_rdata = rf[rf_sel];
    always @(posedge clk) begin
        if (rf_we) rf[rf_sel] <= rf_wdata;
        else if (tb_we) rf[tb_sel] <= tb_val;
    end

    int rd_total = 0;
    always @(posedge clk) if (rst_n && mem_rd_en) rd_total++;

    int nchk = 0, nerr = 0, done_cnt = 0;
    bit finished = 1'b0;

    typedef struct { logic [AW-1:0] op; logic er; string tag; } exp_t;
    exp_t q[$];
    exp_t e;
    logic [AW-1:0] rfm [NREG];

    task automatic chk(input string r, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Monitor: pop and compare on each done, flag wide or unexpected pulses.
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                done_cnt++;
                if (prev_done) chk("R12 done width", 16'd1, 16'd0);
                if (q.size() == 0) chk("R12 unexpected done", 16'd1, 16'd0);
                else begin
                    e = q.pop_front();
                    chk({e.tag, " operand"}, operand, e.op);
                    chk({e.tag, " err"}, {15'd0, err}, {15'd0, e.er});
                end
            end
            prev_done = done;
        end else prev_done = 1'b0;
    end

    task automatic set_reg(input int s, input logic [AW-1:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_sel = RSW'(s); tb_val = v;
        @(negedge clk);
        tb_we = 1'b0;
        rfm[s] = v;
    endtask

    task automatic run_op(input logic [3:0] m, input logic [AW-1:0] f, input int s,
                          input logic [AW-1:0] p, input logic [AW-1:0] x,
                          input string tag, input bit busy_poke);
        logic [AW-1:0] r, op, nr;
        int rd, rd0, dc0;
        bit seen;
        exp_t it;
        r = rfm[s]; nr = r; op = '0; rd = 1;
        case (m)
            4'd0: op = mem_f(f);
            4'd1: begin op = mem_f(mem_f(f)); rd = 2; end
            4'd2: op = mem_f(f + p);
            4'd3: begin op = f; rd = 0; end
            4'd4: op = mem_f(f + x);
            4'd5: begin op = r; rd = 0; end
            4'd6: op = mem_f(r);
            4'd7: begin op = mem_f(r); nr = r + 16'd1; end
            4'd8: begin nr = r - 16'd1; op = mem_f(nr); end
            default: rd = 0;
        endcase
        it.op = op; it.er = (m > 4'd8); it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        rd0 = rd_total; dc0 = done_cnt;
        mode = m; addr_fld = f; reg_sel = RSW'(s); pc = p; idx = x; req = 1'b1;
        @(negedge clk);
        if (busy_poke) begin
            mode = 4'd3; addr_fld = 16'hdead;
            @(negedge clk);
        end
        req = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        repeat (5) @(negedge clk);
        chk({tag, " done count"}, 16'(done_cnt - dc0), 16'd1);
        chk({tag, " reads"}, 16'(rd_total - rd0), 16'(rd));
        chk({tag, " register"}, rf[s], nr);
        rfm[s] = nr;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin rf[i] = '0; rfm[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 err", {15'd0, err}, 16'd0);
        chk("R1 mem_rd_en", {15'd0, mem_rd_en}, 16'd0);
        chk("R1 rf_we", {15'd0, rf_we}, 16'd0);
        chk("R1 operand", operand, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after release", {15'd0, done}, 16'd0);

        set_reg(1, 16'h1234);
        set_reg(2, 16'hffff);
        set_reg(3, 16'h0000);
        set_reg(4, 16'h0800);

        run_op(4'd0, 16'h00a5, 0, 16'h0000, 16'h0000, "R2 direct", 1'b0);
        run_op(4'd0, 16'hffff, 0, 16'h0000, 16'h0000, "R2 direct top", 1'b0);
        run_op(4'd1, 16'h0321, 0, 16'h0000, 16'h0000, "R3 indirect", 1'b0);
        run_op(4'd2, 16'h0040, 0, 16'h1000, 16'h0000, "R4 relative", 1'b0);
        run_op(4'd2, 16'h0020, 0, 16'hfff0, 16'h0000, "R4 relative wrap", 1'b0);
        run_op(4'd3, 16'hbeef, 0, 16'h0000, 16'h0000, "R5 immediate", 1'b0);
        run_op(4'd4, 16'h0100, 0, 16'h0000, 16'h0022, "R6 indexed", 1'b0);
        run_op(4'd4, 16'hff00, 0, 16'h0000, 16'h0200, "R6 indexed wrap", 1'b0);
        run_op(4'd5, 16'h0000, 1, 16'h0000, 16'h0000, "R7 register", 1'b0);
        run_op(4'd6, 16'h0000, 1, 16'h0000, 16'h0000, "R8 reg indirect", 1'b0);
        run_op(4'd7, 16'h0000, 4, 16'h0000, 16'h0000, "R9 autoinc", 1'b0);
        run_op(4'd7, 16'h0000, 4, 16'h0000, 16'h0000, "R9 autoinc again", 1'b0);
        run_op(4'd7, 16'h0000, 2, 16'h0000, 16'h0000, "R9 autoinc wrap", 1'b0);
        run_op(4'd8, 16'h0000, 4, 16'h0000, 16'h0000, "R10 autodec", 1'b0);
        run_op(4'd8, 16'h0000, 3, 16'h0000, 16'h0000, "R10 autodec wrap", 1'b0);
        run_op(4'd9, 16'h1111, 1, 16'h0000, 16'h0000, "R11 illegal 9", 1'b0);
        run_op(4'd15, 16'h2222, 1, 16'h0000, 16'h0000, "R11 illegal 15", 1'b0);
        run_op(4'd1, 16'h7777, 0, 16'h0000, 16'h0000, "R12 busy request", 1'b1);
        run_op(4'd3, 16'h5a5a, 0, 16'h0000, 16'h0000, "R12 after busy", 1'b0);

        chk("R12 leftover expectations", 16'(q.size()), 16'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule